// File: doc/BRIEF.md
# Huffman Tree-Walk Stream Decoder

The block turns a stream of code bits into a stream of 8-bit characters. It walks a binary code tree that sits in an on-chip tree memory. Before a run, the tree is loaded one node at a time through a plain write port. A start pulse puts the walker at the root, which is always at address 0. Each accepted input bit moves the walk to the left or right child. When the walk lands on a leaf, the block pushes that leaf's character into an output FIFO and goes back to the root. This return step does not take an input bit.

Input tokens arrive on a valid/ready stream. A token is either a data bit or an end marker. The end marker closes the run: the block writes one terminating word after the characters already decoded, and any path that was only partly walked is dropped. Once that terminating word has left the output FIFO, the block raises `done` and holds it until the next start pulse.

Each tree node is one word of `2*PTR_W+1` bits, 19 bits at the defaults. The top bit is a tag. A branch carries two child pointers and a leaf carries a character in its low bits. The tree memory reads synchronously, so each step of the walk costs one fetch cycle plus one decision cycle.

Top module: `hdec_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `outValid`, `inReady` and `done` are all 0.
- R2: A node with bit 18 = 0 is a branch: bits [17:9] point to the left child and bits [8:0] to the right child. An accepted bit of 0 goes left and a bit of 1 goes right. A node with bit 18 = 1 is a leaf, and its character is in bits [7:0]. The walk begins at the node at address 0.
- R3: Emitting a leaf's character takes no input bit. The next bit is decoded starting from the root.
- R4: An accepted end token (`inNil` = 1) produces exactly one terminating output word (`outNil` = 1, `outChar` = 0) after all characters decoded before it. A path that was only partly walked yields no character, and no input is accepted after the end token.
- R5: Output words leave in decode order, and none is lost while `outReady` is low. While `outValid` is high and `outReady` is low, `outChar` and `outNil` stay stable.
- R6: `done` rises only after the terminating word has been taken and the output FIFO is empty. It then stays high until `start`, and `outValid` is 0 while `done` is high.
- R7: A `start` pulse in any state clears `done` and returns the walk to the root. Any partly walked path is dropped.
- R8: `inReady` is high only while the walker sits on a fetched branch node. No token is accepted before the first `start`, or while `done` is high.
- R9: A node written through the tree write port between runs is used by every later decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: restart the walk at the root |
| treeWrEn | input | 1 | Tree node write enable |
| treeWrAddr | input | PTR_W | Tree node write address |
| treeWrData | input | 2*PTR_W+1 | Tree node word |
| inValid | input | 1 | Input token valid |
| inReady | output | 1 | Input token accepted this cycle when valid |
| inBit | input | 1 | Code bit (0 left, 1 right) |
| inNil | input | 1 | Token is the end-of-stream marker |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Consumer takes the output word |
| outChar | output | CHAR_W | Decoded character |
| outNil | output | 1 | Output word is the terminating marker |
| done | output | 1 | Run finished and output drained |

## Verification
The assertions assume three things about the inputs. The tree holds no leaf at the root. Every branch pointer names a node that has been written. The tree is not rewritten while a walk is in progress. The stimulus keeps to these assumptions: it loads each tree only while the block is idle or done, and it uses only complete code trees whose leaves sit at depth one or more. The checks also assume that `outReady` may drop at any cycle, so the bench throttles the consumer with a fixed pattern during one of the sweeps.

// File: rtl/hdec_pkg.sv
package hdec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECIDE,
    ST_END,
    ST_DRAIN,
    ST_DONE
  } walkState_t;

  // strobes from the walk controller to the datapath
  typedef struct packed {
    logic fetch;     // read the node at the current pointer
    logic toRoot;    // pointer back to address 0
    logic step;      // follow child selected by input bit
    logic pushChar;  // queue leaf character
    logic pushNil;   // queue terminating word
  } walkStrobe_t;

endpackage

// File: rtl/hdec_tree_ram.sv
module hdec_tree_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  // one-cycle synchronous read
  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/hdec_fifo.sv
module hdec_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  assign full     = (count == FULLCNT);
  assign empty    = (count == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/hdec_ctrl.sv
module hdec_ctrl
  import hdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inValid,
  input  logic        inNil,
  input  logic        nodeIsLeaf,
  input  logic        fifoFull,
  input  logic        fifoEmpty,
  output walkStrobe_t strobe,
  output logic        inReady,
  output logic        done
);
  walkState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    inReady   = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: ;
      ST_FETCH: begin
        strobe.fetch = 1'b1;
        stateNext    = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (nodeIsLeaf) begin
          // emit, then restart at the root without taking a bit
          if (!fifoFull) begin
            strobe.pushChar = 1'b1;
            strobe.toRoot   = 1'b1;
            stateNext       = ST_FETCH;
          end
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            if (inNil) begin
              stateNext = ST_END;
            end else begin
              strobe.step = 1'b1;
              stateNext   = ST_FETCH;
            end
          end
        end
      end
      ST_END: begin
        if (!fifoFull) begin
          strobe.pushNil = 1'b1;
          stateNext      = ST_DRAIN;
        end
      end
      ST_DRAIN: if (fifoEmpty) stateNext = ST_DONE;
      ST_DONE: ;
      default: stateNext = ST_IDLE;
    endcase

    if (start) begin
      strobe        = '0;
      strobe.toRoot = 1'b1;
      inReady       = 1'b0;
      stateNext     = ST_FETCH;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign done = (state == ST_DONE);
endmodule

// File: rtl/hdec_dpath.sv
module hdec_dpath
  import hdec_pkg::*;
#(
  parameter int PTR_W      = 9,
  parameter int CHAR_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         strobe,
  input  logic                inBit,
  input  logic                treeWrEn,
  input  logic [PTR_W-1:0]    treeWrAddr,
  input  logic [2*PTR_W:0]    treeWrData,
  input  logic                outReady,
  output logic                nodeIsLeaf,
  output logic                fifoFull,
  output logic                fifoEmpty,
  output logic                outValid,
  output logic [CHAR_W-1:0]   outChar,
  output logic                outNil
);
  localparam int NODE_W = 2 * PTR_W + 1;
  localparam int WORD_W = CHAR_W + 1;

  logic [PTR_W-1:0]  walkPtr;
  logic [NODE_W-1:0] nodeWord;
  logic [PTR_W-1:0]  leftPtr, rightPtr;
  logic [CHAR_W-1:0] leafChar;
  logic [WORD_W-1:0] pushWord, headWord;

  hdec_tree_ram #(.ADDR_W(PTR_W), .DATA_W(NODE_W)) treeRam_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (treeWrEn),
    .wrAddr (treeWrAddr),
    .wrData (treeWrData),
    .rdEn   (strobe.fetch),
    .rdAddr (walkPtr),
    .rdData (nodeWord)
  );

  // node word fields: tag on top, left pointer, right pointer below
  assign nodeIsLeaf = nodeWord[NODE_W-1];
  assign leftPtr    = nodeWord[NODE_W-2 -: PTR_W];
  assign rightPtr   = nodeWord[PTR_W-1:0];
  assign leafChar   = nodeWord[CHAR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)              walkPtr <= '0;
    else if (strobe.toRoot) walkPtr <= '0;
    else if (strobe.step)   walkPtr <= inBit ? rightPtr : leftPtr;
  end

  assign pushWord = strobe.pushNil ? {1'b1, {CHAR_W{1'b0}}} : {1'b0, leafChar};

  hdec_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) outFifo_i (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.pushChar || strobe.pushNil),
    .pushData (pushWord),
    .pop      (outReady),
    .headData (headWord),
    .full     (fifoFull),
    .empty    (fifoEmpty)
  );

  assign outValid = !fifoEmpty;
  assign outNil   = headWord[WORD_W-1];
  assign outChar  = headWord[CHAR_W-1:0];
endmodule

// File: rtl/hdec_top.sv
module hdec_top
  import hdec_pkg::*;
#(
  parameter int PTR_W      = 9,
  parameter int CHAR_W     = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              treeWrEn,
  input  logic [PTR_W-1:0]  treeWrAddr,
  input  logic [2*PTR_W:0]  treeWrData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inBit,
  input  logic              inNil,
  output logic              outValid,
  input  logic              outReady,
  output logic [CHAR_W-1:0] outChar,
  output logic              outNil,
  output logic              done
);
  walkStrobe_t strobe;
  logic nodeIsLeaf, fifoFull, fifoEmpty;

  hdec_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .inValid    (inValid),
    .inNil      (inNil),
    .nodeIsLeaf (nodeIsLeaf),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .strobe     (strobe),
    .inReady    (inReady),
    .done       (done)
  );

  hdec_dpath #(.PTR_W(PTR_W), .CHAR_W(CHAR_W), .FIFO_DEPTH(FIFO_DEPTH)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inBit      (inBit),
    .treeWrEn   (treeWrEn),
    .treeWrAddr (treeWrAddr),
    .treeWrData (treeWrData),
    .outReady   (outReady),
    .nodeIsLeaf (nodeIsLeaf),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .outValid   (outValid),
    .outChar    (outChar),
    .outNil     (outNil)
  );
endmodule

// File: rtl/hdec_chk.sv
module hdec_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              inValid,
  input logic              inReady,
  input logic              inNil,
  input logic              outValid,
  input logic              outReady,
  input logic [CHAR_W-1:0] outChar,
  input logic              outNil,
  input logic              done
);
  // R8
  no_accept_when_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inReady);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outChar) && $stable(outNil)));

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && !inReady));

  // R4
  no_accept_after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inNil) |=> !inReady);
endmodule

bind hdec_top hdec_chk #(.CHAR_W(CHAR_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .inValid  (inValid),
  .inReady  (inReady),
  .inNil    (inNil),
  .outValid (outValid),
  .outReady (outReady),
  .outChar  (outChar),
  .outNil   (outNil),
  .done     (done)
);

// File: tb/hdec_top_tb_top.sv
`timescale 1ns/1ps
module hdec_top_tb_top;
  localparam int PTR_W  = 9;
  localparam int CHAR_W = 8;
  localparam int NODE_W = 2 * PTR_W + 1;
  localparam int TD     = 3;           // depth of the complete tree
  localparam int NSYM   = 1 << TD;
  localparam int KSKEW  = 4;           // symbols in the skewed tree

  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic treeWrEn = 0;
  logic [PTR_W-1:0] treeWrAddr = '0;
  logic [NODE_W-1:0] treeWrData = '0;
  logic inValid = 0, inBit = 0, inNil = 0;
  logic inReady, outValid, outNil, done;
  logic outReady = 1;
  logic [CHAR_W-1:0] outChar;

  always #10 clk = ~clk;

  hdec_top dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .treeWrEn(treeWrEn), .treeWrAddr(treeWrAddr), .treeWrData(treeWrData),
    .inValid(inValid), .inReady(inReady), .inBit(inBit), .inNil(inNil),
    .outValid(outValid), .outReady(outReady), .outChar(outChar), .outNil(outNil),
    .done(done)
  );

  int total = 0, bad = 0;
  logic bitsArr [1024];
  int nb;
  logic [7:0] expArr [256];
  int ne;
  logic [7:0] gotArr [256];
  int gotN = 0;
  int nilCount = 0;
  int charAfterNil = 0;
  logic nilBadChar = 0;
  logic stallMode = 0;
  int cyc = 0;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // consumer: choose outReady for the coming edge, record the word taken there
  always @(negedge clk) begin
    cyc++;
    outReady = stallMode ? ((cyc % 3) == 0) : 1'b1;
    if (outValid && outReady) begin
      if (outNil) begin
        nilCount++;
        if (outChar != 8'h00) nilBadChar = 1;
      end else begin
        if (nilCount != 0) charAfterNil++;
        if (gotN < 256) gotArr[gotN] = outChar;
        gotN++;
      end
    end
  end

  task automatic writeNode(input int addr, input logic [NODE_W-1:0] word);
    treeWrEn = 1; treeWrAddr = PTR_W'(addr); treeWrData = word;
    @(negedge clk);
    treeWrEn = 0;
  endtask

  function automatic logic [NODE_W-1:0] branchWord(input int l, input int r);
    return {1'b0, PTR_W'(l), PTR_W'(r)};
  endfunction

  function automatic logic [NODE_W-1:0] leafWord(input logic [7:0] c);
    return {1'b1, {(NODE_W-9){1'b0}}, c};
  endfunction

  task automatic sendTok(input logic b, input logic n);
    logic acc;
    inValid = 1; inBit = b; inNil = n;
    while (1) begin
      acc = inReady;
      @(negedge clk);
      if (acc) break;
    end
    inValid = 0;
  endtask

  task automatic pulseStart();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // runs bitsArr then the end token; midStart sends one stray bit first
  task automatic runCase(input string tag, input logic midStart);
    logic earlyDone;
    gotN = 0; nilCount = 0; charAfterNil = 0; nilBadChar = 0; earlyDone = 0;
    pulseStart();
    if (midStart) begin
      sendTok(1'b1, 1'b0);
      repeat (3) @(negedge clk);
      pulseStart();
    end
    for (int i = 0; i < nb; i++) sendTok(bitsArr[i], 1'b0);
    sendTok(1'b0, 1'b1);
    for (int w = 0; w < 4000; w++) begin
      if (done) begin
        if (nilCount == 0) earlyDone = 1;
        break;
      end
      @(negedge clk);
    end
    check({tag, " R6 done raised"}, done, done, 1);
    check({tag, " R6 done only after end word"}, !earlyDone, earlyDone, 0);
    check({tag, " R6 output empty while done"}, !outValid, outValid, 0);
    check({tag, " R4 one end word"}, nilCount == 1, nilCount, 1);
    check({tag, " R4 end word last, char zero"}, charAfterNil == 0 && !nilBadChar,
          charAfterNil, 0);
    check({tag, " R5 char count"}, gotN == ne, gotN, ne);
    for (int i = 0; i < ne && i < gotN; i++)
      check({tag, " R2 R3 char"}, gotArr[i] == expArr[i], gotArr[i], expArr[i]);
    repeat (4) @(negedge clk);
    check({tag, " R6 done held"}, done, done, 1);
  endtask

  // complete tree: node i branches to 2i+1, 2i+2; leaf for path value v at NSYM-1+v
  task automatic loadComplete();
    for (int i = 0; i < NSYM - 1; i++) writeNode(i, branchWord(2*i+1, 2*i+2));
    for (int v = 0; v < NSYM; v++) writeNode(NSYM - 1 + v, leafWord(8'h41 + 8'(v)));
  endtask

  task automatic addSymComplete(input int s);
    for (int k = TD - 1; k >= 0; k--) begin
      bitsArr[nb] = s[k]; nb++;
    end
    expArr[ne] = 8'h41 + 8'(s); ne++;
  endtask

  // skewed tree: branch at 2j -> leaf 2j+1 (left) / 2j+2 (right); last node a leaf
  task automatic loadSkew();
    for (int j = 0; j < KSKEW - 1; j++) begin
      writeNode(2*j, branchWord(2*j+1, 2*j+2));
      writeNode(2*j+1, leafWord(8'h61 + 8'(j)));
    end
    writeNode(2*(KSKEW-1), leafWord(8'h61 + 8'(KSKEW-1)));
  endtask

  task automatic addSymSkew(input int s);
    for (int k = 0; k < s; k++) begin bitsArr[nb] = 1'b1; nb++; end
    if (s < KSKEW - 1) begin bitsArr[nb] = 1'b0; nb++; end
    expArr[ne] = 8'h61 + 8'(s); ne++;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: while in reset
    check("R1 outValid in reset", !outValid, outValid, 0);
    check("R1 inReady in reset", !inReady, inReady, 0);
    check("R1 done in reset", !done, done, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 idle after reset", !outValid && !inReady && !done, {outValid, inReady, done}, 0);

    // R8: offered tokens before any start are never taken
    begin
      logic taken = 0;
      inValid = 1; inBit = 1;
      for (int i = 0; i < 10; i++) begin
        if (inReady) taken = 1;
        @(negedge clk);
      end
      inValid = 0;
      check("R8 no accept before start", !taken, taken, 0);
    end

    loadComplete();

    // sweep every symbol of the complete tree (R2, R3)
    nb = 0; ne = 0;
    for (int s = 0; s < NSYM; s++) addSymComplete(s);
    runCase("all-symbols", 1'b0);

    // R8: while done no token is taken
    begin
      logic taken = 0;
      inValid = 1;
      for (int i = 0; i < 6; i++) begin
        if (inReady) taken = 1;
        @(negedge clk);
      end
      inValid = 0;
      check("R8 no accept while done", !taken, taken, 0);
    end

    // longer arithmetic sequence under consumer stalls (R5)
    stallMode = 1;
    nb = 0; ne = 0;
    for (int k = 0; k < 48; k++) addSymComplete((k * 5 + 3) % NSYM);
    runCase("stalled", 1'b0);
    stallMode = 0;

    // partial path at end is dropped (R4)
    nb = 0; ne = 0;
    addSymComplete(6);
    bitsArr[nb] = 1'b1; nb++;
    bitsArr[nb] = 1'b0; nb++;
    runCase("partial-tail R4", 1'b0);

    // empty stream (R4)
    nb = 0; ne = 0;
    runCase("empty R4", 1'b0);

    // start while partway down the tree (R7)
    nb = 0; ne = 0;
    addSymComplete(5);
    addSymComplete(0);
    runCase("mid-start R7", 1'b1);

    // reload a different tree through the write port (R9)
    loadSkew();
    nb = 0; ne = 0;
    for (int k = 0; k < 24; k++) addSymSkew((k * 3 + 1) % KSKEW);
    runCase("skewed R9", 1'b0);

    finishRun();
  end
endmodule